// File: doc/BRIEF.md
# Dirty Page Update Coalescer

This block walks a framebuffer's per-page dirty bitmap once per frame and turns it into a short list of redraw rectangles. Every bitmap page stands for a fixed group of four display lines. Consecutive dirty pages are joined into one rectangle. Each rectangle leaves the block as a start line and a line count on a valid/ready port.

The bitmap itself lives outside the block. The block reads it one bit per cycle, in ascending page order, through a request/acknowledge port. While it scans, it records the lowest and highest dirty page. After the last rectangle it issues a single range-clear command for that span, so the bitmap owner can reset the touched pages in one operation.

An invalidate pulse forces the following scan to treat every page as dirty. That scan then redraws the full screen without reading the bitmap. A frame-start pulse that arrives while a scan is running is remembered and starts one more scan afterwards. A one-cycle done pulse marks the end of each scan.

Top module: `dirty_span_merger`

## Requirements
- R1: Page p covers lines LINES_PER_PAGE*p up to LINES_PER_PAGE*p+LINES_PER_PAGE-1 (four lines per page by default). Every update therefore has a start line and a line count that are non-zero multiples of LINES_PER_PAGE, except that the start line may be zero.
- R2: A run of consecutive dirty pages produces exactly one update. Its start line is the first line of the first page in the run.
- R3: When a clean page p follows a run, the update for that run is issued with count = LINES_PER_PAGE*p − start. Separate runs produce separate updates in ascending line order.
- R4: A run that is still open after the last page is issued with count = LINES_PER_PAGE*NUM_PAGES − start.
- R5: After all updates, one clear command is issued with lo = the lowest dirty page number and hi = the highest, so lo ≤ hi < NUM_PAGES.
- R6: A scan that finds no dirty page issues no update and no clear command.
- R7: A pulse on inval_all_i makes the next scan treat every page as dirty. That scan makes no bitmap requests, issues one update (0, LINES_PER_PAGE*NUM_PAGES) and a clear (0, NUM_PAGES−1). The effect is used up by that scan.
- R8: A frame_start_i pulse during a scan is held. Exactly one further scan runs after the current one ends.
- R9: done_o is high for exactly one cycle. It comes in the cycle after the last accepted handshake of the scan (read, update or clear). No two of bm_req_o, upd_valid_o, clr_valid_o and done_o are ever high together.
- R10: bm_req_o with bm_page_o, and upd_valid_o with its fields, stay asserted and unchanged until they are accepted by bm_ack_i or upd_ready_i. Pages are read in ascending order, one per acknowledge, and bm_dirty_i is sampled in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start_i | input | 1 | Pulse that starts a scan |
| inval_all_i | input | 1 | Pulse that forces the next scan to see every page as dirty |
| bm_req_o | output | 1 | Bitmap read request |
| bm_page_o | output | PAGE_W | Page being read |
| bm_ack_i | input | 1 | Read accepted; bm_dirty_i valid |
| bm_dirty_i | input | 1 | Dirty bit of bm_page_o |
| upd_valid_o | output | 1 | Update rectangle valid |
| upd_ready_i | input | 1 | Update accepted |
| upd_line_o | output | LINE_W | First line of the update |
| upd_count_o | output | LINE_W | Number of lines in the update |
| clr_valid_o | output | 1 | Range-clear command valid |
| clr_ready_i | input | 1 | Clear accepted |
| clr_lo_o | output | PAGE_W | Lowest dirty page |
| clr_hi_o | output | PAGE_W | Highest dirty page |
| done_o | output | 1 | One-cycle end-of-scan pulse |

## Verification
The bench targets runs that touch page 0 or the last page. A design with an off-by-one page-to-line mapping, or one that forgets the end-of-frame flush, would report a wrong start line or drop the final rectangle. It also runs a scan with no dirty pages: a design that tests the min/max pair wrongly would issue a spurious clear of an empty range. Acknowledge stalls and update backpressure are mixed in to catch a design that advances a page or changes an output before it is accepted. A second start pulse during a scan, and an invalidate followed by a clean scan, catch a design that drops the held start or leaves the forced-dirty state active.

// File: rtl/dpc_pkg.sv
// Package: shared types for the dirty page update coalescer.
// Assumes nothing beyond being compiled before the modules that import it.
package dpc_pkg;

    // Scan controller states
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a frame start
        ST_READ,   // reading (or forcing) the current page's dirty bit
        ST_UPD,    // offering a run closed by a clean page
        ST_TAIL,   // offering the run left open at the end of the frame
        ST_CLR,    // offering the range clear
        ST_DONE    // one-cycle end-of-scan marker
    } scan_st_e;

endpackage

// File: rtl/dpc_run_tracker.sv
// Module: dpc_run_tracker
// Tracks the currently open run of dirty pages and computes the update
// that closes it, either on a clean page or at the end of the frame.
// Assumes eval pulses once per page, in ascending page order, and that
// scan_start clears the run before the first page of each scan.
module dpc_run_tracker #(
    parameter int NUM_PAGES      = 192,
    parameter int LINES_PER_PAGE = 4,
    parameter int PAGE_W         = 8,
    parameter int LINE_W         = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_start,
    input  logic              eval,
    input  logic [PAGE_W-1:0] page,
    input  logic              dirty,
    output logic              close_emit,
    output logic [LINE_W-1:0] close_line,
    output logic [LINE_W-1:0] close_cnt,
    output logic              tail_open,
    output logic [LINE_W-1:0] tail_line,
    output logic [LINE_W-1:0] tail_cnt
);
    localparam int FRAME_LINES = NUM_PAGES * LINES_PER_PAGE;
    localparam bit LPP_POW2    = (LINES_PER_PAGE & (LINES_PER_PAGE - 1)) == 0;
    localparam int LPP_SHIFT   = $clog2(LINES_PER_PAGE);

    logic              run_open;
    logic [LINE_W-1:0] run_start;
    logic [LINE_W-1:0] page_line;
    logic [LINE_W-1:0] start_after;

    // First line of the current page: shift when lines per page is a power of two
    generate
        if (LPP_POW2) begin : g_shift
            always_comb page_line = LINE_W'(page) << LPP_SHIFT;
        end else begin : g_mult
            always_comb page_line = LINE_W'(page) * LINE_W'(LINES_PER_PAGE);
        end
    endgenerate

    // Close / extend decisions for the page under evaluation
    always_comb begin
        close_emit  = run_open && !dirty;
        close_line  = run_start;
        close_cnt   = page_line - run_start;
        start_after = run_open ? run_start : page_line;
        tail_open   = dirty;
        tail_line   = start_after;
        tail_cnt    = LINE_W'(FRAME_LINES) - start_after;
    end

    // Run state: opens on a dirty page, closes on a clean page
    always_ff @(posedge clk) begin
        if (!rst_n || scan_start) begin
            run_open  <= 1'b0;
            run_start <= '0;
        end else if (eval) begin
            run_open  <= dirty;
            run_start <= dirty ? start_after : run_start;
        end
    end

endmodule

// File: rtl/dpc_range_tracker.sv
// Module: dpc_range_tracker
// Keeps the lowest and highest dirty page seen in the current scan.
// The low mark starts at all-ones and the high mark at zero, so the
// span is non-empty exactly when low <= high.
// Assumes PAGE_W can hold NUM_PAGES, so all-ones is never a real page.
module dpc_range_tracker #(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_start,
    input  logic              eval,
    input  logic [PAGE_W-1:0] page,
    input  logic              dirty,
    output logic [PAGE_W-1:0] lo,
    output logic [PAGE_W-1:0] hi,
    output logic              any_dirty
);

    // Non-empty span test
    always_comb any_dirty = (lo <= hi);

    // Min/max update on every dirty page
    always_ff @(posedge clk) begin
        if (!rst_n || scan_start) begin
            lo <= '1;
            hi <= '0;
        end else if (eval && dirty) begin
            if (page < lo) lo <= page;
            if (page > hi) hi <= page;
        end
    end

endmodule

// File: rtl/dpc_scan_ctrl.sv
// Module: dpc_scan_ctrl
// Sequences one scan: walks the pages, reads dirty bits (or forces them
// after an invalidate), stalls on the update and clear handshakes, and
// ends with a one-cycle done marker. Holds a start request that arrives
// while busy and an invalidate until the next scan begins.
// Assumes run and range trackers update on the eval strobe it produces.
module dpc_scan_ctrl
    import dpc_pkg::*;
#(
    parameter int NUM_PAGES = 192,
    parameter int PAGE_W    = 8,
    parameter int LINE_W    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start_i,
    input  logic              inval_all_i,
    input  logic              bm_ack_i,
    input  logic              bm_dirty_i,
    input  logic              upd_ready_i,
    input  logic              clr_ready_i,
    input  logic              close_emit,
    input  logic [LINE_W-1:0] close_line,
    input  logic [LINE_W-1:0] close_cnt,
    input  logic              tail_open,
    input  logic [LINE_W-1:0] tail_line,
    input  logic [LINE_W-1:0] tail_cnt,
    input  logic              any_dirty,
    output logic              scan_start,
    output logic              eval,
    output logic              eval_dirty,
    output logic [PAGE_W-1:0] page,
    output logic              bm_req_o,
    output logic              upd_valid_o,
    output logic [LINE_W-1:0] upd_line_o,
    output logic [LINE_W-1:0] upd_count_o,
    output logic              clr_valid_o,
    output logic              done_o
);
    localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(NUM_PAGES - 1);

    scan_st_e          state_q, state_d;
    logic [PAGE_W-1:0] page_q, page_d;
    logic [LINE_W-1:0] line_q, line_d;
    logic [LINE_W-1:0] cnt_q, cnt_d;
    logic              start_pend_q;
    logic              inval_pend_q;
    logic              force_q;
    logic              last_page;
    scan_st_e          finish_st;

    // Strobes and port outputs derived from the state
    always_comb begin
        last_page   = (page_q == LAST_PAGE);
        finish_st   = any_dirty ? ST_CLR : ST_DONE;
        scan_start  = (state_q == ST_IDLE) && (frame_start_i || start_pend_q);
        eval        = (state_q == ST_READ) && (force_q || bm_ack_i);
        eval_dirty  = force_q || bm_dirty_i;
        page        = page_q;
        bm_req_o    = (state_q == ST_READ) && !force_q;
        upd_valid_o = (state_q == ST_UPD) || (state_q == ST_TAIL);
        upd_line_o  = line_q;
        upd_count_o = cnt_q;
        clr_valid_o = (state_q == ST_CLR);
        done_o      = (state_q == ST_DONE);
    end

    // Next-state, page and pending-update selection
    always_comb begin
        state_d = state_q;
        page_d  = page_q;
        line_d  = line_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (scan_start) begin
                    state_d = ST_READ;
                    page_d  = '0;
                end
            end
            ST_READ: begin
                if (eval) begin
                    if (close_emit) begin
                        state_d = ST_UPD;
                        line_d  = close_line;
                        cnt_d   = close_cnt;
                    end else if (last_page) begin
                        if (tail_open) begin
                            state_d = ST_TAIL;
                            line_d  = tail_line;
                            cnt_d   = tail_cnt;
                        end else begin
                            state_d = finish_st;
                        end
                    end else begin
                        page_d = page_q + PAGE_W'(1);
                    end
                end
            end
            ST_UPD: begin
                if (upd_ready_i) begin
                    if (last_page) begin
                        state_d = finish_st;
                    end else begin
                        state_d = ST_READ;
                        page_d  = page_q + PAGE_W'(1);
                    end
                end
            end
            ST_TAIL: begin
                if (upd_ready_i) state_d = ST_CLR;
            end
            ST_CLR: begin
                if (clr_ready_i) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, page and pending-update registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            page_q  <= '0;
            line_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            page_q  <= page_d;
            line_q  <= line_d;
            cnt_q   <= cnt_d;
        end
    end

    // Held frame start: set while busy, consumed when the next scan starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pend_q <= 1'b0;
        end else if (scan_start) begin
            start_pend_q <= 1'b0;
        end else if (frame_start_i && (state_q != ST_IDLE)) begin
            start_pend_q <= 1'b1;
        end
    end

    // Invalidate: held until a scan starts, then forces that whole scan
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inval_pend_q <= 1'b0;
            force_q      <= 1'b0;
        end else if (scan_start) begin
            inval_pend_q <= 1'b0;
            force_q      <= inval_pend_q || inval_all_i;
        end else if (inval_all_i) begin
            inval_pend_q <= 1'b1;
        end
    end

endmodule

// File: rtl/dirty_span_merger.sv
// Module: dirty_span_merger (top)
// Scans a per-page dirty bitmap once per frame, merges consecutive dirty
// pages into line-range updates and ends with one range-clear command.
// Assumes the bitmap owner answers each request with a single-cycle
// acknowledge carrying the dirty bit of the requested page.
module dirty_span_merger #(
    parameter int NUM_PAGES      = 192,
    parameter int LINES_PER_PAGE = 4,
    parameter int PAGE_W         = $clog2(NUM_PAGES + 1),
    parameter int LINE_W         = $clog2(NUM_PAGES * LINES_PER_PAGE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start_i,
    input  logic              inval_all_i,
    output logic              bm_req_o,
    output logic [PAGE_W-1:0] bm_page_o,
    input  logic              bm_ack_i,
    input  logic              bm_dirty_i,
    output logic              upd_valid_o,
    input  logic              upd_ready_i,
    output logic [LINE_W-1:0] upd_line_o,
    output logic [LINE_W-1:0] upd_count_o,
    output logic              clr_valid_o,
    input  logic              clr_ready_i,
    output logic [PAGE_W-1:0] clr_lo_o,
    output logic [PAGE_W-1:0] clr_hi_o,
    output logic              done_o
);
    logic              scan_start;
    logic              eval;
    logic              eval_dirty;
    logic [PAGE_W-1:0] page;
    logic              close_emit;
    logic [LINE_W-1:0] close_line;
    logic [LINE_W-1:0] close_cnt;
    logic              tail_open;
    logic [LINE_W-1:0] tail_line;
    logic [LINE_W-1:0] tail_cnt;
    logic              any_dirty;

    // Page address to the bitmap port
    always_comb bm_page_o = page;

    dpc_scan_ctrl #(
        .NUM_PAGES (NUM_PAGES),
        .PAGE_W    (PAGE_W),
        .LINE_W    (LINE_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start_i),
        .inval_all_i   (inval_all_i),
        .bm_ack_i      (bm_ack_i),
        .bm_dirty_i    (bm_dirty_i),
        .upd_ready_i   (upd_ready_i),
        .clr_ready_i   (clr_ready_i),
        .close_emit    (close_emit),
        .close_line    (close_line),
        .close_cnt     (close_cnt),
        .tail_open     (tail_open),
        .tail_line     (tail_line),
        .tail_cnt      (tail_cnt),
        .any_dirty     (any_dirty),
        .scan_start    (scan_start),
        .eval          (eval),
        .eval_dirty    (eval_dirty),
        .page          (page),
        .bm_req_o      (bm_req_o),
        .upd_valid_o   (upd_valid_o),
        .upd_line_o    (upd_line_o),
        .upd_count_o   (upd_count_o),
        .clr_valid_o   (clr_valid_o),
        .done_o        (done_o)
    );

    dpc_run_tracker #(
        .NUM_PAGES      (NUM_PAGES),
        .LINES_PER_PAGE (LINES_PER_PAGE),
        .PAGE_W         (PAGE_W),
        .LINE_W         (LINE_W)
    ) u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_start (scan_start),
        .eval       (eval),
        .page       (page),
        .dirty      (eval_dirty),
        .close_emit (close_emit),
        .close_line (close_line),
        .close_cnt  (close_cnt),
        .tail_open  (tail_open),
        .tail_line  (tail_line),
        .tail_cnt   (tail_cnt)
    );

    dpc_range_tracker #(
        .PAGE_W (PAGE_W)
    ) u_range (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_start (scan_start),
        .eval       (eval),
        .page       (page),
        .dirty      (eval_dirty),
        .lo         (clr_lo_o),
        .hi         (clr_hi_o),
        .any_dirty  (any_dirty)
    );

endmodule

// File: rtl/dirty_span_merger_chk.sv
// Module: dirty_span_merger_chk
// Port-level protocol and range properties of dirty_span_merger,
// attached to every instance of the top module through bind.
module dirty_span_merger_chk #(
    parameter int NUM_PAGES      = 192,
    parameter int LINES_PER_PAGE = 4,
    parameter int PAGE_W         = 8,
    parameter int LINE_W         = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start_i,
    input logic              inval_all_i,
    input logic              bm_req_o,
    input logic [PAGE_W-1:0] bm_page_o,
    input logic              bm_ack_i,
    input logic              bm_dirty_i,
    input logic              upd_valid_o,
    input logic              upd_ready_i,
    input logic [LINE_W-1:0] upd_line_o,
    input logic [LINE_W-1:0] upd_count_o,
    input logic              clr_valid_o,
    input logic              clr_ready_i,
    input logic [PAGE_W-1:0] clr_lo_o,
    input logic [PAGE_W-1:0] clr_hi_o,
    input logic              done_o
);

    // R10
    upd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid_o && !upd_ready_i) |=>
            (upd_valid_o && $stable(upd_line_o) && $stable(upd_count_o)));

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_req_o && !bm_ack_i) |=> (bm_req_o && $stable(bm_page_o)));

    // R1
    upd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid_o |-> ((upd_count_o != '0)
            && ((int'(upd_line_o) % LINES_PER_PAGE) == 0)
            && ((int'(upd_count_o) % LINES_PER_PAGE) == 0)));

    // R4
    upd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid_o |->
            ((int'(upd_line_o) + int'(upd_count_o)) <= NUM_PAGES * LINES_PER_PAGE));

    // R5
    clr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid_o |-> ((clr_lo_o <= clr_hi_o) && (int'(clr_hi_o) < NUM_PAGES)));

    // R9
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bm_req_o, upd_valid_o, clr_valid_o, done_o}));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

bind dirty_span_merger dirty_span_merger_chk #(
    .NUM_PAGES      (NUM_PAGES),
    .LINES_PER_PAGE (LINES_PER_PAGE),
    .PAGE_W         (PAGE_W),
    .LINE_W         (LINE_W)
) u_chk (.*);

// File: tb/dirty_span_merger_tb.sv
// Directed bench for dirty_span_merger: one task per scenario, each
// comparing the logged commands with a model built from the requirements.
module dirty_span_merger_tb;
    localparam int NP  = 16;
    localparam int LPP = 4;
    localparam int PW  = 5;
    localparam int LW  = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start_i = 1'b0;
    logic          inval_all_i = 1'b0;
    logic          bm_req_o;
    logic [PW-1:0] bm_page_o;
    logic          bm_ack_i = 1'b0;
    logic          bm_dirty_i = 1'b0;
    logic          upd_valid_o;
    logic          upd_ready_i = 1'b0;
    logic [LW-1:0] upd_line_o;
    logic [LW-1:0] upd_count_o;
    logic          clr_valid_o;
    logic          clr_ready_i = 1'b0;
    logic [PW-1:0] clr_lo_o;
    logic [PW-1:0] clr_hi_o;
    logic          done_o;

    always #4 clk = ~clk;

    dirty_span_merger #(.NUM_PAGES(NP), .LINES_PER_PAGE(LPP)) u_dut (.*);

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [NP-1:0] bitmap = '0;
    bit stall_en = 0;
    bit bp_en = 0;
    int n_upd = 0;
    int upd_l[64];
    int upd_c[64];
    int n_clr = 0;
    int clr_l = 0;
    int clr_h = 0;
    int n_done = 0;
    int done_cyc = 0;
    int last_act = 0;
    int req_cnt = 0;

    // Bitmap responder, sinks and logger, all on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            bm_ack_i   = bm_req_o && (!stall_en || (cyc % 2 == 0));
            bm_dirty_i = bm_ack_i ? bitmap[bm_page_o[3:0]] : 1'b0;
            upd_ready_i = !bp_en || (cyc % 3 != 0);
            clr_ready_i = !bp_en || (cyc % 3 != 1);
            if (rst_n) begin
                if (bm_req_o) req_cnt++;
                if (bm_ack_i) last_act = cyc;
                if (upd_valid_o && upd_ready_i) begin
                    if (n_upd < 64) begin
                        upd_l[n_upd] = int'(upd_line_o);
                        upd_c[n_upd] = int'(upd_count_o);
                    end
                    n_upd++;
                    last_act = cyc;
                end
                if (clr_valid_o && clr_ready_i) begin
                    n_clr++;
                    clr_l = int'(clr_lo_o);
                    clr_h = int'(clr_hi_o);
                    last_act = cyc;
                end
                if (done_o) begin
                    n_done++;
                    done_cyc = cyc;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic clear_logs();
        n_upd = 0; n_clr = 0; n_done = 0; req_cnt = 0; last_act = 0; done_cyc = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); frame_start_i = 1'b1;
        @(negedge clk); frame_start_i = 1'b0;
    endtask

    task automatic wait_done(input int target, input string tag);
        int t = 0;
        while (n_done < target && t < 4000) begin
            @(negedge clk);
            t++;
        end
        check(n_done >= target, tag, "watchdog scan done count", n_done, target);
    endtask

    // Compare logged commands with the run/range model of the requirements
    task automatic compare_scan(input string tag, input logic [NP-1:0] bm, input bit forced);
        int el[64];
        int ec[64];
        int ne = 0;
        bit open = 0;
        int s = 0;
        int lo = 1000;
        int hi = -1;
        for (int p = 0; p < NP; p++) begin
            bit d = forced || bm[p];
            if (d) begin
                if (!open) begin open = 1; s = p * LPP; end   // R2 run start
                if (p < lo) lo = p;
                if (p > hi) hi = p;
            end else if (open) begin
                el[ne] = s; ec[ne] = p * LPP - s; ne++; open = 0;  // R3 close
            end
        end
        if (open) begin el[ne] = s; ec[ne] = NP * LPP - s; ne++; end  // R4 tail
        check(n_upd == ne, tag, "R2 R3 update count", n_upd, ne);
        for (int i = 0; i < ne && i < n_upd; i++) begin
            check(upd_l[i] == el[i], tag, "R1 update start line", upd_l[i], el[i]);
            check(upd_c[i] == ec[i], tag, "R3 R4 update line count", upd_c[i], ec[i]);
        end
        if (hi < 0) begin
            check(n_clr == 0, tag, "R6 clear count", n_clr, 0);
        end else begin
            check(n_clr == 1, tag, "R5 clear count", n_clr, 1);
            check(clr_l == lo, tag, "R5 clear lo", clr_l, lo);
            check(clr_h == hi, tag, "R5 clear hi", clr_h, hi);
        end
        check(done_cyc == last_act + 1, tag, "R9 done cycle", done_cyc, last_act + 1);
        check(n_done == 1, tag, "R9 done pulses", n_done, 1);
    endtask

    task automatic run_scan(input string tag, input logic [NP-1:0] bm, input bit st, input bit bp);
        bitmap = bm; stall_en = st; bp_en = bp;
        clear_logs();
        pulse_start();
        wait_done(1, tag);
        @(negedge clk);
        compare_scan(tag, bm, 1'b0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!bm_req_o && !upd_valid_o && !clr_valid_o && !done_o, "R9",
              "reset outputs idle", int'({bm_req_o, upd_valid_o, clr_valid_o, done_o}), 0);
    endtask

    task automatic t_none();
        run_scan("R6", '0, 0, 0);                        // no update, no clear
        check(req_cnt == NP, "R10", "one read per page", req_cnt, NP);
    endtask

    task automatic t_single();
        run_scan("R1", 16'h0020, 0, 0);                  // page 5: (20,4), clear 5..5
    endtask

    task automatic t_two_runs();
        run_scan("R3", 16'h021C, 0, 0);                  // (8,12) (36,4), clear 2..9
    endtask

    task automatic t_edges();
        run_scan("R4", 16'hE001, 0, 0);                  // (0,4) (52,12), clear 0..15
    endtask

    task automatic t_stall();
        run_scan("R10", 16'hB6D3, 1, 1);                 // stalls on reads and outputs
    endtask

    task automatic t_invalidate();
        bitmap = '0; stall_en = 0; bp_en = 1;
        clear_logs();
        @(negedge clk); inval_all_i = 1'b1;
        @(negedge clk); inval_all_i = 1'b0;
        pulse_start();
        wait_done(1, "R7");
        @(negedge clk);
        compare_scan("R7", '0, 1'b1);                    // (0,64), clear 0..15
        check(req_cnt == 0, "R7", "no bitmap reads in forced scan", req_cnt, 0);
        run_scan("R7", '0, 0, 0);                        // forcing used up
    endtask

    task automatic t_held();
        bitmap = 16'h0F0F; stall_en = 1; bp_en = 0;
        clear_logs();
        pulse_start();
        repeat (3) @(negedge clk);
        frame_start_i = 1'b1;
        @(negedge clk); frame_start_i = 1'b0;
        wait_done(1, "R8");
        compare_scan("R8", 16'h0F0F, 1'b0);
        clear_logs();
        wait_done(1, "R8");
        @(negedge clk);
        compare_scan("R8", 16'h0F0F, 1'b0);
        clear_logs();
        repeat (80) @(negedge clk);
        check(n_done == 0, "R8", "no extra scan", n_done, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_none();
        t_single();
        t_two_runs();
        t_edges();
        t_stall();
        t_invalidate();
        t_held();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Global watchdog
    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule